// File: doc/BRIEF.md
# ALU Condition Flag Unit

This block derives the six arithmetic condition flags (carry, parity, auxiliary carry, zero, sign, overflow) from one integer ALU operation and keeps them in a status register. Each cycle the ALU presents its two operands, its result, and the carry or borrow out of the selected width. It also presents an operation class and an operand size of 8, 16 or 32 bits. The unit works out the flags for that operation and loads them into the register on the same clock edge.

A flag-write strobe shows whether the presented operation alters the flags. Data moves and control transfers use the "no flags" class. They leave the register exactly as it was, so a later conditional branch still sees the flags of the last arithmetic or logic operation. The block has no separate state machine. Its only state is the six-bit flag register, which has two transitions: *load* when the strobe is high, and *hold* when it is low.

Top module: `alu_flag_unit`

## Requirements
- R1: For the add class (`op_class`=1) and the subtract class (`op_class`=2), the carry flag takes `alu_carry`, which is the carry out of an addition or the borrow out of a subtraction at the selected size.
- R2: The parity flag is 1 when `alu_result[7:0]` holds an even number of ones, including none, and 0 when that count is odd, whatever the operand size.
- R3: The auxiliary carry flag is 1 when a carry (add) or a borrow (subtract) passes from bit 3 into bit 4. It equals `op_a[4]^op_b[4]^alu_result[4]`.
- R4: The zero flag is 1 exactly when the result bits inside the selected size are all zero. Result bits above that size are ignored.
- R5: The sign flag copies the top bit of the result at the selected size. `op_size` 0 selects bit 7, 1 selects bit 15, and 2 or 3 select bit 31.
- R6: Overflow for add is set when both operands have the same top bit and the result's top bit differs from it. For subtract, it is set when the operands' top bits differ and the result's top bit differs from `op_a`'s.
- R7: For the logic class (`op_class`=3), carry, overflow and auxiliary carry are loaded as 0, whatever `alu_carry` holds.
- R8: For the no-flags class (`op_class`=0), `flag_we` is 0 and all six flags keep their values.
- R9: An active-low reset clears all six flags to 0.
- R10: `flag_we` is 1 in the same cycle as any class other than 0, and the flags it enables appear on the outputs after that clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| op_a | input | 32 | First ALU operand |
| op_b | input | 32 | Second ALU operand |
| alu_result | input | 32 | ALU result; only the bits inside the selected size are meaningful |
| alu_carry | input | 1 | Carry out (add) or borrow out (subtract) at the selected size |
| op_class | input | 2 | 0 no flags, 1 add, 2 subtract, 3 logic |
| op_size | input | 2 | 0 = 8 bit, 1 = 16 bit, 2 or 3 = 32 bit |
| flag_we | output | 1 | High when this operation updates the flags |
| flag_cf | output | 1 | Carry flag |
| flag_pf | output | 1 | Parity flag |
| flag_af | output | 1 | Auxiliary carry flag |
| flag_zf | output | 1 | Zero flag |
| flag_sf | output | 1 | Sign flag |
| flag_of | output | 1 | Overflow flag |

## Verification
The flag register is the block's only state. A wrong value loaded into it shows on the flag outputs one edge after the operation, and it stays there until the next flag-writing operation. A hold that fails during a no-flags cycle is therefore visible one edge later as a changed output. The bench runs a behavioural model alongside the design. The model derives every flag from signed and unsigned integer arithmetic and nibble sums. On every clock it compares the model's flags and write strobe with the outputs. This catches a bad value in the first cycle it appears.

// File: rtl/alu_flag_pkg.sv
package alu_flag_pkg;

    typedef enum logic [1:0] {
        OPC_NONE  = 2'd0,
        OPC_ADD   = 2'd1,
        OPC_SUB   = 2'd2,
        OPC_LOGIC = 2'd3
    } op_class_e;

    typedef enum logic [1:0] {
        SZ_BYTE  = 2'd0,
        SZ_WORD  = 2'd1,
        SZ_DWORD = 2'd2,
        SZ_RSVD  = 2'd3
    } op_size_e;

    typedef struct packed {
        logic cf;
        logic pf;
        logic af;
        logic zf;
        logic sf;
        logic of;
    } flags_t;

endpackage

// File: rtl/flag_size_view.sv
module flag_size_view
    import alu_flag_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  op_size_e            sz,
    input  logic [DATA_W-1:0]   a,
    input  logic [DATA_W-1:0]   b,
    input  logic [DATA_W-1:0]   r,
    output logic                a_msb,
    output logic                b_msb,
    output logic                r_msb,
    output logic                r_zero
);
    localparam int LANES = 3;

    logic [LANES-1:0] a_top;
    logic [LANES-1:0] b_top;
    logic [LANES-1:0] r_top;
    logic [LANES-1:0] r_nil;

    // lane i covers DATA_W >> (2 - i) bits: 8, 16, 32 for the default width
    for (genvar i = 0; i < LANES; i++) begin : g_lane
        localparam int LW = DATA_W >> (LANES - 1 - i);
        assign a_top[i] = a[LW-1];
        assign b_top[i] = b[LW-1];
        assign r_top[i] = r[LW-1];
        assign r_nil[i] = (r[LW-1:0] == '0);
    end

    always_comb begin
        unique case (sz)
            SZ_BYTE: begin
                a_msb = a_top[0]; b_msb = b_top[0];
                r_msb = r_top[0]; r_zero = r_nil[0];
            end
            SZ_WORD: begin
                a_msb = a_top[1]; b_msb = b_top[1];
                r_msb = r_top[1]; r_zero = r_nil[1];
            end
            default: begin
                a_msb = a_top[2]; b_msb = b_top[2];
                r_msb = r_top[2]; r_zero = r_nil[2];
            end
        endcase
    end
endmodule

// File: rtl/flag_arith_calc.sv
module flag_arith_calc
    import alu_flag_pkg::*;
(
    input  op_class_e cls,
    input  logic      carry_in,
    input  logic      a_msb,
    input  logic      b_msb,
    input  logic      r_msb,
    input  logic      a_bit4,
    input  logic      b_bit4,
    input  logic      r_bit4,
    output logic      cf,
    output logic      af,
    output logic      of
);
    logic nib_cross;

    // carry or borrow entering bit 4 is the only term left after cancelling operand bits
    assign nib_cross = a_bit4 ^ b_bit4 ^ r_bit4;

    always_comb begin
        cf = 1'b0;
        af = 1'b0;
        of = 1'b0;
        unique case (cls)
            OPC_ADD: begin
                cf = carry_in;
                af = nib_cross;
                of = (a_msb == b_msb) && (r_msb != a_msb);
            end
            OPC_SUB: begin
                cf = carry_in;
                af = nib_cross;
                of = (a_msb != b_msb) && (r_msb != a_msb);
            end
            default: begin
                cf = 1'b0;
                af = 1'b0;
                of = 1'b0;
            end
        endcase
    end
endmodule

// File: rtl/flag_result_calc.sv
module flag_result_calc #(
    parameter int PAR_W = 8
) (
    input  logic [PAR_W-1:0] r_low,
    input  logic             r_zero,
    input  logic             r_msb,
    output logic             pf,
    output logic             zf,
    output logic             sf
);
    assign pf = ~(^r_low);
    assign zf = r_zero;
    assign sf = r_msb;
endmodule

// File: rtl/alu_flag_unit.sv
module alu_flag_unit
    import alu_flag_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int PAR_W  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [DATA_W-1:0] op_a,
    input  logic [DATA_W-1:0] op_b,
    input  logic [DATA_W-1:0] alu_result,
    input  logic              alu_carry,
    input  logic [1:0]        op_class,
    input  logic [1:0]        op_size,
    output logic              flag_we,
    output logic              flag_cf,
    output logic              flag_pf,
    output logic              flag_af,
    output logic              flag_zf,
    output logic              flag_sf,
    output logic              flag_of
);
    op_class_e cls;
    op_size_e  sz;
    logic      a_msb, b_msb, r_msb, r_zero;
    flags_t    next_flags;
    flags_t    flag_q;
    logic      unused_inputs;

    assign cls = op_class_e'(op_class);
    assign sz  = op_size_e'(op_size);
    assign unused_inputs = ^{op_a, op_b, alu_result};

    flag_size_view #(.DATA_W(DATA_W)) u_view (
        .sz     (sz),
        .a      (op_a),
        .b      (op_b),
        .r      (alu_result),
        .a_msb  (a_msb),
        .b_msb  (b_msb),
        .r_msb  (r_msb),
        .r_zero (r_zero)
    );

    flag_arith_calc u_arith (
        .cls      (cls),
        .carry_in (alu_carry),
        .a_msb    (a_msb),
        .b_msb    (b_msb),
        .r_msb    (r_msb),
        .a_bit4   (op_a[4]),
        .b_bit4   (op_b[4]),
        .r_bit4   (alu_result[4]),
        .cf       (next_flags.cf),
        .af       (next_flags.af),
        .of       (next_flags.of)
    );

    flag_result_calc #(.PAR_W(PAR_W)) u_result (
        .r_low  (alu_result[PAR_W-1:0]),
        .r_zero (r_zero),
        .r_msb  (r_msb),
        .pf     (next_flags.pf),
        .zf     (next_flags.zf),
        .sf     (next_flags.sf)
    );

    assign flag_we = (cls != OPC_NONE);

    // status register: load on a flag-writing class, hold otherwise
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            flag_q <= '0;
        else if (flag_we)
            flag_q <= next_flags;
    end

    assign flag_cf = flag_q.cf;
    assign flag_pf = flag_q.pf;
    assign flag_af = flag_q.af;
    assign flag_zf = flag_q.zf;
    assign flag_sf = flag_q.sf;
    assign flag_of = flag_q.of;

    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !flag_we |=> $stable(flag_q)) else $error("idle class changed flags"); // R8
    AST_LOGIC_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_we && cls == OPC_LOGIC) |=> (!flag_cf && !flag_of && !flag_af)) else $error("logic left cf/of/af set"); // R7
    AST_ZERO_EVEN: assert property (@(posedge clk) disable iff (!rst_n)
        flag_zf |-> flag_pf) else $error("zero result with odd parity"); // R2
    AST_ZERO_POSITIVE: assert property (@(posedge clk) disable iff (!rst_n)
        flag_zf |-> !flag_sf) else $error("zero result with sign set"); // R5
    AST_ADD_SAME_SIGN: assert property (@(posedge clk) disable iff (!rst_n)
        (cls == OPC_ADD && a_msb != b_msb) |=> !flag_of) else $error("mixed-sign add overflowed"); // R6
endmodule

// File: tb/alu_flag_unit_test.sv
`timescale 1ns/1ps
module alu_flag_unit_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] op_a = '0, op_b = '0, alu_result = '0;
    logic        alu_carry = 1'b0;
    logic [1:0]  op_class = 2'd0, op_size = 2'd0;
    logic        flag_we, flag_cf, flag_pf, flag_af, flag_zf, flag_sf, flag_of;

    int checks = 0;
    int errors = 0;
    bit done = 0;
    // model flags: cf pf af zf sf of
    logic [5:0] model = '0;
    logic [31:0] lfsr = 32'h1234_5678;

    always #2 clk = ~clk;

    alu_flag_unit uut (
        .clk(clk), .rst_n(rst_n), .op_a(op_a), .op_b(op_b),
        .alu_result(alu_result), .alu_carry(alu_carry),
        .op_class(op_class), .op_size(op_size), .flag_we(flag_we),
        .flag_cf(flag_cf), .flag_pf(flag_pf), .flag_af(flag_af),
        .flag_zf(flag_zf), .flag_sf(flag_sf), .flag_of(flag_of)
    );

    task automatic check(input string req, input string what, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%b expected=%b", req, what, act, exp);
        end
    endtask

    task automatic check_flags(input string tag);
        check({"R1 ", tag}, "cf", flag_cf, model[5]);
        check({"R2 ", tag}, "pf", flag_pf, model[4]);
        check({"R3 ", tag}, "af", flag_af, model[3]);
        check({"R4 ", tag}, "zf", flag_zf, model[2]);
        check({"R5 ", tag}, "sf", flag_sf, model[1]);
        check({"R6 ", tag}, "of", flag_of, model[0]);
    endtask

    function automatic int width_of(input logic [1:0] s);
        case (s)
            2'd0: return 8;
            2'd1: return 16;
            default: return 32;
        endcase
    endfunction

    // drive one operation: cls 0 none, 1 add, 2 sub, 3 logic(and)
    task automatic run_op(input logic [31:0] a, input logic [31:0] b, input logic [1:0] cls,
                          input logic [1:0] sz, input logic [31:0] junk, input logic junk_cy);
        int w;
        longint mask, am, bm, rm, sa, sb, sr, lo, hi;
        logic cy;
        logic [31:0] r;
        logic [5:0] nxt;
        w = width_of(sz);
        mask = (longint'(1) << w) - 1;
        am = longint'(a) & mask;
        bm = longint'(b) & mask;
        cy = junk_cy;
        case (cls)
            2'd1: begin rm = (am + bm) & mask; cy = ((am + bm) >> w) != 0; end
            2'd2: begin rm = (am - bm) & mask; cy = am < bm; end
            2'd3: rm = am & bm;
            default: rm = longint'(junk) & mask;
        endcase
        r = 32'(rm) | (junk & ~32'(mask));
        @(negedge clk);
        op_a = a; op_b = b; alu_result = r; alu_carry = cy;
        op_class = cls; op_size = sz;
        #1;
        check("R10 R8", "flag_we", flag_we, cls != 2'd0);
        sa = ((am >> (w-1)) & 1) != 0 ? am - (longint'(1) << w) : am;
        sb = ((bm >> (w-1)) & 1) != 0 ? bm - (longint'(1) << w) : bm;
        lo = -(longint'(1) << (w-1));
        hi = (longint'(1) << (w-1)) - 1;
        if (cls != 2'd0) begin
            nxt[5] = (cls == 2'd3) ? 1'b0 : cy;
            nxt[4] = ($countones(r[7:0]) % 2) == 0;
            nxt[3] = (cls == 2'd1) ? (((am & 15) + (bm & 15)) > 15) :
                     (cls == 2'd2) ? ((am & 15) < (bm & 15)) : 1'b0;
            nxt[2] = rm == 0;
            nxt[1] = ((rm >> (w-1)) & 1) != 0;
            if (cls == 2'd1) begin sr = sa + sb; nxt[0] = (sr < lo) || (sr > hi); end
            else if (cls == 2'd2) begin sr = sa - sb; nxt[0] = (sr < lo) || (sr > hi); end
            else nxt[0] = 1'b0;
            model = nxt;
        end
        @(posedge clk);
        #1;
        check_flags(cls == 2'd0 ? "R8 hold" : (cls == 2'd3 ? "R7 logic" : "arith"));
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        check_flags("R9 reset");
        rst_n = 1'b1;
        // R1 R4 carry out and zero at byte size, junk above
        run_op(32'hAB00_00FF, 32'h0000_0001, 2'd1, 2'd0, 32'hFFFF_FF00, 1'b0);
        // R6 signed byte overflow 0x7F+1
        run_op(32'h7F, 32'h01, 2'd1, 2'd0, 32'h0, 1'b0);
        // R3 half borrow, R1 borrow at word
        run_op(32'h0000_0010, 32'h0000_0001, 2'd2, 2'd1, 32'h0, 1'b0);
        run_op(32'h0000_0000, 32'h0000_0001, 2'd2, 2'd1, 32'h5A5A_0000, 1'b0);
        // R6 word subtract overflow 0x8000-1
        run_op(32'h0000_8000, 32'h0000_0001, 2'd2, 2'd1, 32'h0, 1'b0);
        // R8 hold with garbage
        run_op(32'hFFFF_FFFF, 32'h1, 2'd0, 2'd2, 32'h0, 1'b1);
        run_op(32'h0, 32'h0, 2'd0, 2'd0, 32'h0, 1'b0);
        // R7 logic with carry input high
        run_op(32'h8000_000F, 32'hF000_0003, 2'd3, 2'd2, 32'h0, 1'b1);
        // R5 size code 3 selects bit 31
        run_op(32'h7FFF_FFFF, 32'h1, 2'd1, 2'd3, 32'h0, 1'b0);
        run_op(32'hFFFF_FFFF, 32'h1, 2'd1, 2'd2, 32'h0, 1'b0);
        // R2 parity only over low byte
        run_op(32'h0000_0100, 32'h0000_0003, 2'd1, 2'd1, 32'h0, 1'b0);
        for (int i = 0; i < 300; i++) begin
            logic [31:0] x, y;
            lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
            x = lfsr;
            lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
            y = lfsr ^ {lfsr[15:0], lfsr[31:16]};
            run_op(x, y, x[3:2], y[1:0], {y[7:0], x[31:8]}, x[9]);
        end
        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule